// File: doc/BRIEF.md
# Reloadable Millisecond Countdown Timer

This block is a general purpose countdown timer with an 8-bit count in units of one millisecond. A prescaler divides the master clock (4.032 MHz by default, so 4032 clocks per tick) to produce the millisecond tick. Each tick lowers an internal count. When the count reaches zero the block raises a sticky expiry flag for a neighbouring interrupt controller. Depending on the re-cycle control bit, the timer then reloads itself from the stored preset or stops.

Software-side logic drives a one-cycle preset write strobe with an 8-bit value, the enable and re-cycle control bits, and a one-cycle flag-clear pulse. The flag-clear pulse marks the read of the flag register. No port carries streaming data, so no port needs a valid/ready handshake. Every input is a plain level or a single-cycle strobe that is sampled on each rising clock edge. The internal count and the running state are brought out so that the count can be observed.

Top module: `ms_countdown_timer`

## Requirements
- R1: After reset the count is 0, the timer is not running and the expiry flag is 0.
- R2: A preset write with a non-zero value stores the value, copies it into the count on the same clock edge, and starts the timer.
- R3: While the timer runs and the enable is 1, the count drops by one after every TICK_DIV clocks. The first drop comes TICK_DIV clocks after the load.
- R4: While the enable is 0, the count and the prescaler phase hold their values.
- R5: A 0-to-1 change of the enable reloads the count from the stored preset and restarts the timer, provided the stored preset is non-zero.
- R6: When the count steps from 1 to 0 with re-cycle = 0, the expiry flag is set and the timer stops with a count of 0. It stays stopped until a preset write or an enable rising edge.
- R7: When the count would step from 1 to 0 with re-cycle = 1, the expiry flag is set and the count reloads from the preset on the same edge. Counting then continues.
- R8: Re-cycle is sampled only at expiry. Clearing it part-way through a count lets that count finish, and the timer then stops.
- R9: A preset of 0 powers the timer down: the count is 0, the timer is not running, no expiry occurs, and an enable rising edge does not start it.
- R10: The expiry flag stays 1 until a flag-clear pulse. If an expiry and a clear fall on the same edge, the flag is set.
- R11: Every reload caused by a write or an enable edge restarts the prescaler. After a write in the middle of an interval, the next drop comes a full TICK_DIV clocks later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| preset_wr | input | 1 | One-cycle strobe that writes the preset |
| preset_val | input | CNT_W | Preset value in milliseconds |
| tmr_en | input | 1 | Count enable; its rising edge restarts the timer |
| tmr_recycle | input | 1 | 1 = auto-reload at expiry, 0 = one-shot |
| flag_clr | input | 1 | One-cycle pulse marking the read of the flag register |
| count_o | output | CNT_W | Current internal count |
| active_o | output | 1 | Timer is running (it counts while enabled) |
| expired_flag_o | output | 1 | Sticky expiry flag |

## Verification
The bound checker watches, on every cycle, the rules that link a single edge to its inputs:
- a write loads its value;
- a zero write powers the timer down;
- a disabled timer holds its count;
- a stopped timer reads zero;
- the flag stays set until cleared and drops on a clear when no expiry can occur.

Multi-interval behaviour can only be shown by the bench's scenarios: the TICK_DIV spacing of drops, expiry timing, auto-reload against one-shot, the late change of re-cycle, and the prescaler restart after a mid-interval rewrite. The bench runs these scenarios against its behavioural model with a short divider.

// File: rtl/gpt_pkg.sv
package gpt_pkg;
  typedef enum logic {
    TMR_OFF = 1'b0,
    TMR_RUN = 1'b1
  } tmr_state_e;
endpackage

// File: rtl/gpt_ms_prescale.sv
module gpt_ms_prescale #(
  parameter int TICK_DIV = 4032
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic tick
);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

  logic [PW-1:0] phase_q;

  assign tick = run && !clr && (phase_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       phase_q <= '0;
    else if (clr)     phase_q <= '0;
    else if (tick)    phase_q <= '0;
    else if (run)     phase_q <= phase_q + PW'(1);
  end
endmodule

// File: rtl/gpt_count_core.sv
module gpt_count_core
  import gpt_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [CNT_W-1:0] wr_val,
  input  logic             en,
  input  logic             recycle,
  input  logic             tick,
  output logic             load,
  output logic             run,
  output logic             expire,
  output logic [CNT_W-1:0] count,
  output logic             active
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] preset_q;
  logic [CNT_W-1:0] cnt_q;
  logic             en_q;
  tmr_state_e       state_q;
  logic             en_rise;

  assign en_rise = en && !en_q;
  assign load    = wr || en_rise;
  assign run     = (state_q == TMR_RUN) && en;
  assign expire  = tick && !load && (cnt_q == ONE);
  assign count   = cnt_q;
  assign active  = (state_q == TMR_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      preset_q <= '0;
      cnt_q    <= '0;
      en_q     <= 1'b0;
      state_q  <= TMR_OFF;
    end else begin
      en_q <= en;
      if (wr) begin
        preset_q <= wr_val;
        cnt_q    <= wr_val;
        state_q  <= (wr_val != '0) ? TMR_RUN : TMR_OFF;
      end else if (en_rise) begin
        cnt_q   <= preset_q;
        state_q <= (preset_q != '0) ? TMR_RUN : TMR_OFF;
      end else if (expire) begin
        if (recycle) begin
          cnt_q <= preset_q;
        end else begin
          cnt_q   <= '0;
          state_q <= TMR_OFF;
        end
      end else if (tick) begin
        cnt_q <= cnt_q - ONE;
      end
    end
  end
endmodule

// File: rtl/gpt_expiry_flag.sv
module gpt_expiry_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    flag <= 1'b0;
    else if (set)  flag <= 1'b1;
    else if (clr)  flag <= 1'b0;
  end
endmodule

// File: rtl/ms_countdown_timer.sv
module ms_countdown_timer #(
  parameter int CNT_W    = 8,
  parameter int TICK_DIV = 4032
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             preset_wr,
  input  logic [CNT_W-1:0] preset_val,
  input  logic             tmr_en,
  input  logic             tmr_recycle,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] count_o,
  output logic             active_o,
  output logic             expired_flag_o
);
  logic load_w, run_w, tick_w, expire_w;

  gpt_ms_prescale #(.TICK_DIV(TICK_DIV)) presc_i (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (load_w),
    .run   (run_w),
    .tick  (tick_w)
  );

  gpt_count_core #(.CNT_W(CNT_W)) core_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (preset_wr),
    .wr_val  (preset_val),
    .en      (tmr_en),
    .recycle (tmr_recycle),
    .tick    (tick_w),
    .load    (load_w),
    .run     (run_w),
    .expire  (expire_w),
    .count   (count_o),
    .active  (active_o)
  );

  gpt_expiry_flag flag_i (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (expire_w),
    .clr   (flag_clr),
    .flag  (expired_flag_o)
  );
endmodule

// File: rtl/gpt_checker.sv
module gpt_checker #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             preset_wr,
  input logic [CNT_W-1:0] preset_val,
  input logic             tmr_en,
  input logic             tmr_recycle,
  input logic             flag_clr,
  input logic [CNT_W-1:0] count_o,
  input logic             active_o,
  input logic             expired_flag_o
);
  a_r2_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
    preset_wr |=> (count_o == $past(preset_val)));

  a_r2_nonzero_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (preset_wr && preset_val != '0) |=> active_o);

  a_r4_hold_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (!tmr_en && !preset_wr) |=> $stable(count_o));

  a_r9_zero_write_off: assert property (@(posedge clk) disable iff (!rst_n)
    (preset_wr && preset_val == '0) |=> !active_o);

  a_r6_stopped_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !active_o |-> (count_o == '0));

  a_r10_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (expired_flag_o && !flag_clr) |=> expired_flag_o);

  a_r10_clear_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !active_o) |=> !expired_flag_o);

  a_r8_recycle_unused_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_o && !preset_wr && !tmr_en) |=> (!active_o && $stable(count_o)));
endmodule

bind ms_countdown_timer gpt_checker #(.CNT_W(CNT_W)) chk_i (.*);

// File: tb/ms_countdown_timer_tb.sv
module ms_countdown_timer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 8;
  localparam int W          = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         preset_wr = 1'b0;
  logic [W-1:0] preset_val = '0;
  logic         tmr_en = 1'b0;
  logic         tmr_recycle = 1'b0;
  logic         flag_clr = 1'b0;
  logic [W-1:0] count_o;
  logic         active_o;
  logic         expired_flag_o;

  int    n_chk = 0;
  int    n_err = 0;
  int    cycles = 0;
  bit    done = 1'b0;
  string cur_req = "R1";

  ms_countdown_timer #(.CNT_W(W), .TICK_DIV(DIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .preset_wr(preset_wr), .preset_val(preset_val),
    .tmr_en(tmr_en), .tmr_recycle(tmr_recycle), .flag_clr(flag_clr),
    .count_o(count_o), .active_o(active_o), .expired_flag_o(expired_flag_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference model
  int m_pre = 0, m_cnt = 0, m_ph = 0;
  bit m_run = 0, m_flag = 0, m_enq = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pre = 0; m_cnt = 0; m_ph = 0; m_run = 0; m_flag = 0; m_enq = 0;
    end else begin
      bit ev;
      ev = 0;
      if (preset_wr) begin
        m_pre = preset_val; m_cnt = preset_val; m_ph = 0; m_run = (preset_val != 0);
      end else if (tmr_en && !m_enq) begin
        m_cnt = m_pre; m_ph = 0; m_run = (m_pre != 0);
      end else if (m_run && tmr_en) begin
        if (m_ph == DIV - 1) begin
          m_ph = 0;
          if (m_cnt == 1) begin
            ev = 1;
            if (tmr_recycle) m_cnt = m_pre;
            else begin m_cnt = 0; m_run = 0; end
          end else m_cnt = m_cnt - 1;
        end else m_ph = m_ph + 1;
      end
      if (ev) m_flag = 1;
      else if (flag_clr) m_flag = 0;
      m_enq = tmr_en;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(cur_req, "model count", int'(count_o), m_cnt);
      chk(cur_req, "model active", int'(active_o), int'(m_run));
      chk(cur_req, "model flag", int'(expired_flag_o), int'(m_flag));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1'b1;
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=timeout expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  task automatic wait_n(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic write_preset(int v);
    preset_wr = 1'b1; preset_val = W'(v);
    @(negedge clk);
    preset_wr = 1'b0;
  endtask

  task automatic pulse_clr();
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
  endtask

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "reset count", int'(count_o), 0);
    chk("R1", "reset active", int'(active_o), 0);
    chk("R1", "reset flag", int'(expired_flag_o), 0);

    // R2 / R3 / R6: one-shot
    cur_req = "R2"; tmr_en = 1'b1; @(negedge clk);
    write_preset(3);
    chk("R2", "loaded count", int'(count_o), 3);
    chk("R2", "running", int'(active_o), 1);
    cur_req = "R3";
    wait_n(DIV - 1);
    chk("R3", "no drop before interval", int'(count_o), 3);
    wait_n(1);
    chk("R3", "first drop", int'(count_o), 2);
    cur_req = "R6";
    wait_n(2 * DIV);
    chk("R6", "flag at expiry", int'(expired_flag_o), 1);
    chk("R6", "count at expiry", int'(count_o), 0);
    chk("R6", "stopped", int'(active_o), 0);
    wait_n(3 * DIV);
    chk("R6", "stays stopped", int'(count_o), 0);
    cur_req = "R10";
    chk("R10", "flag sticky", int'(expired_flag_o), 1);
    pulse_clr();
    chk("R10", "flag cleared", int'(expired_flag_o), 0);

    // R7: auto-reload
    cur_req = "R7"; tmr_recycle = 1'b1;
    write_preset(2);
    wait_n(2 * DIV);
    chk("R7", "flag on reload", int'(expired_flag_o), 1);
    chk("R7", "count reloaded", int'(count_o), 2);
    chk("R7", "still running", int'(active_o), 1);
    pulse_clr();
    wait_n(2 * DIV - 1);
    chk("R7", "second expiry flag", int'(expired_flag_o), 1);
    pulse_clr();

    // R8: re-cycle cleared mid-count
    cur_req = "R8";
    write_preset(3);
    wait_n(4);
    tmr_recycle = 1'b0;
    wait_n(3 * DIV - 4 - 1);
    chk("R8", "count before finish", int'(count_o), 1);
    wait_n(1);
    chk("R8", "finished and stopped", int'(active_o), 0);
    chk("R8", "finish flag", int'(expired_flag_o), 1);
    pulse_clr();

    // R4 / R5: hold and restart
    cur_req = "R4";
    write_preset(5);
    wait_n(DIV + 2);
    tmr_en = 1'b0;
    @(negedge clk);
    wait_n(40);
    chk("R4", "held count", int'(count_o), 4);
    chk("R4", "still active", int'(active_o), 1);
    cur_req = "R5";
    tmr_en = 1'b1;
    @(negedge clk);
    chk("R5", "reload on enable edge", int'(count_o), 5);
    wait_n(DIV);
    chk("R5", "counting after restart", int'(count_o), 4);

    // R11: prescaler restart on rewrite
    cur_req = "R11";
    write_preset(4);
    wait_n(5);
    write_preset(4);
    wait_n(DIV - 1);
    chk("R11", "no early drop", int'(count_o), 4);
    wait_n(1);
    chk("R11", "full interval drop", int'(count_o), 3);

    // R9: zero preset
    cur_req = "R9";
    write_preset(0);
    chk("R9", "off count", int'(count_o), 0);
    chk("R9", "off active", int'(active_o), 0);
    tmr_en = 1'b0; @(negedge clk);
    tmr_en = 1'b1; @(negedge clk);
    wait_n(3 * DIV);
    chk("R9", "enable edge ignored", int'(active_o), 0);
    chk("R9", "no expiry", int'(expired_flag_o), 0);

    // R10: set wins over clear
    cur_req = "R10";
    write_preset(1);
    flag_clr = 1'b1;
    wait_n(DIV);
    chk("R10", "set beats clear", int'(expired_flag_o), 1);
    wait_n(1);
    chk("R10", "clear next cycle", int'(expired_flag_o), 0);
    flag_clr = 1'b0;
    wait_n(2);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule